// File: doc/BRIEF.md
# Multicycle Integer Multiply Unit

This block is the multiply unit for a 32-bit processor datapath. It takes two register operands and a two-bit opcode. The opcode selects a signed or an unsigned multiply, at full width or at half width. A full-width multiply forms the whole 64-bit product and writes it into a pair of dedicated result registers, one for the high word and one for the low word. A half-width multiply takes the low 16 bits of each operand and writes a 32-bit product into the low result register only.

The unit runs as a fixed-latency iterative engine. It latches the operands when it accepts a start request. It then adds one partial product per cycle, taking one 8-bit digit of the multiplier each time. A final cycle writes the result registers and the condition flags. A `busy` level and a one-cycle `done` pulse frame each operation. The flag output carries a matching per-flag write-enable vector, so the surrounding pipeline can merge the flags into its status word. Instruction decode and the general register file stay outside the block.

Top module: `mul_unit`

## Requirements
- R1: With `op` = 2'b00 (full signed), the two's-complement 64-bit product of `opA` and `opB` appears as {`mdHi`,`mdLo`}. This value is visible in the cycle in which `done` is high.
- R2: With `op` = 2'b01 (full unsigned), the unsigned 64-bit product of `opA` and `opB` appears as {`mdHi`,`mdLo`}.
- R3: With `op` = 2'b10 (half signed) or 2'b11 (half unsigned), bits 15:0 of each operand are used. They are sign-extended for 2'b10 and zero-extended for 2'b11. The 32-bit product goes to `mdLo`, and `mdHi` keeps its previous value.
- R4: A start request is accepted on a rising edge at which `start` is 1 and `busy` is 0. `done` is high in the cycle that follows the 5th rising edge after acceptance for full-width ops, and the 3rd rising edge for half-width ops. `busy` is 1 from acceptance until the edge that raises `done`.
- R5: `done` is a single-cycle pulse. `mdHi`, `mdLo` and `flags` change only at the edge that raises `done`.
- R6: A `start` that is asserted while `busy` is 1 is ignored. The running operation keeps its latency and its operands.
- R7: Full-width flags use the bit order `flags`[3]=N, [2]=Z, [1]=V, [0]=C. N is product bit 63, and Z is 1 when all 64 product bits are 0. V is 1 when the product does not fit in 32 bits: for signed ops, `mdHi` differs from the sign extension of `mdLo`[31]; for unsigned ops, `mdHi` is nonzero. During `done`, `flagWe` = 4'b1110.
- R8: Half-width flags are N = `mdLo`[31] and Z = (`mdLo` == 0). During `done`, `flagWe` = 4'b1100, which leaves V and C unchanged.
- R9: `flagWe` is 4'b0000 in every cycle where `done` is 0. The C enable (`flagWe`[0]) is never set.
- R10: After reset, `busy`, `done`, `mdHi`, `mdLo`, `flags` and `flagWe` are all zero.
- R11: A start presented in the same cycle as `done` is accepted at the next edge, so operations can run back to back with no idle cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Synchronous reset, active low |
| start | input | 1 | Request to begin a multiply |
| op | input | 2 | Bit 1: half width; bit 0: unsigned |
| opA | input | 32 | Multiplicand operand |
| opB | input | 32 | Multiplier operand |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle pulse when results are written |
| mdHi | output | 32 | High result register |
| mdLo | output | 32 | Low result register |
| flags | output | 4 | N, Z, V, C flag values |
| flagWe | output | 4 | Per-flag write enables, valid with done |

## Verification
Two events can fall in the same cycle. The first is the write-back of one result, when `done` is high and `busy` has just dropped. The second is the acceptance of the next start, which reloads the operand registers. The bench provokes this by chaining random operations with no idle cycle. It judges the case by checking both products and the exact latency of the second operation. A start can also arrive while the unit is busy. The bench provokes this by injecting a start with different operands one cycle into a run, and judges it by requiring the original latency and the original operands' product.

// File: rtl/mul_unit_pkg.sv
package mul_unit_pkg;

  // opcode bit meanings
  localparam int OP_HALF_BIT = 1;
  localparam int OP_UNS_BIT  = 0;

  // flag vector bit positions
  localparam int FLAG_N = 3;
  localparam int FLAG_Z = 2;
  localparam int FLAG_V = 1;
  localparam int FLAG_C = 0;
  localparam int FLAG_W = 4;

  // width of the digit index carried from control to datapath
  localparam int CTL_IDX_W = 4;

  // strobes from control to datapath
  typedef struct packed {
    logic                 load;   // latch operands, clear accumulator
    logic                 step;   // add one partial product
    logic                 write;  // commit results and flags
    logic [CTL_IDX_W-1:0] idx;    // multiplier digit in use
  } mulCtl_t;

endpackage

// File: rtl/mul_unit_ctrl.sv
module mul_unit_ctrl
  import mul_unit_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int DIGIT_W = 8
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  logic [1:0] op,
  output mulCtl_t    ctl,
  output logic       busy,
  output logic       done
);

  localparam int HALF_W     = DATA_W / 2;
  localparam int FULL_STEPS = DATA_W / DIGIT_W;
  localparam int HALF_STEPS = HALF_W / DIGIT_W;
  localparam int CNT_W      = $clog2(FULL_STEPS + 1);

  logic                 busyQ;
  logic                 doneQ;
  logic [CNT_W-1:0]     cntQ;
  logic [CTL_IDX_W-1:0] idxQ;
  logic                 accept;
  logic                 lastCycle;

  assign accept    = start && !busyQ;
  assign lastCycle = busyQ && (cntQ == '0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busyQ <= 1'b0;
      doneQ <= 1'b0;
      cntQ  <= '0;
      idxQ  <= '0;
    end else begin
      doneQ <= lastCycle;
      if (accept) begin
        busyQ <= 1'b1;
        cntQ  <= op[OP_HALF_BIT] ? CNT_W'(HALF_STEPS) : CNT_W'(FULL_STEPS);
        idxQ  <= '0;
      end else if (busyQ) begin
        if (cntQ == '0) begin
          busyQ <= 1'b0;
        end else begin
          cntQ <= cntQ - 1'b1;
          idxQ <= idxQ + 1'b1;
        end
      end
    end
  end

  always_comb begin
    ctl.load  = accept;
    ctl.step  = busyQ && (cntQ != '0);
    ctl.write = lastCycle;
    ctl.idx   = idxQ;
  end

  assign busy = busyQ;
  assign done = doneQ;

endmodule

// File: rtl/mul_unit_dp.sv
module mul_unit_dp
  import mul_unit_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int DIGIT_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  mulCtl_t           ctl,
  input  logic [1:0]        op,
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  output logic [DATA_W-1:0] mdHi,
  output logic [DATA_W-1:0] mdLo,
  output logic [FLAG_W-1:0] flags,
  output logic [FLAG_W-1:0] flagWe
);

  localparam int PROD_W     = 2 * DATA_W;
  localparam int HALF_W     = DATA_W / 2;
  localparam int FULL_STEPS = DATA_W / DIGIT_W;
  localparam int HALF_STEPS = HALF_W / DIGIT_W;
  localparam int SEL_W      = (FULL_STEPS > 1) ? $clog2(FULL_STEPS) : 1;
  localparam int FULL_TOP   = FULL_STEPS - 1;
  localparam int HALF_TOP   = HALF_STEPS - 1;

  logic [PROD_W-1:0] aQ;
  logic [DATA_W-1:0] bQ;
  logic              halfQ;
  logic              signedQ;
  logic [PROD_W-1:0] accQ;
  logic [DATA_W-1:0] mdHiQ;
  logic [DATA_W-1:0] mdLoQ;
  logic [FLAG_W-1:0] flagsQ;
  logic [FLAG_W-1:0] flagWeQ;

  // operand extension at load time
  logic [PROD_W-1:0] aExt;
  logic [DATA_W-1:0] bLoad;
  logic              inSigned;
  logic              inHalf;

  assign inSigned = !op[OP_UNS_BIT];
  assign inHalf   = op[OP_HALF_BIT];

  always_comb begin
    if (inHalf) begin
      aExt  = {{(PROD_W-HALF_W){inSigned && opA[HALF_W-1]}}, opA[HALF_W-1:0]};
      bLoad = {{(DATA_W-HALF_W){1'b0}}, opB[HALF_W-1:0]};
    end else begin
      aExt  = {{(PROD_W-DATA_W){inSigned && opA[DATA_W-1]}}, opA};
      bLoad = opB;
    end
  end

  // digit slicing and partial product placement
  logic [DIGIT_W-1:0] digitArr   [FULL_STEPS];
  logic [PROD_W-1:0]  shiftedArr [FULL_STEPS];
  logic [SEL_W-1:0]   sel;
  logic [DIGIT_W-1:0] digit;
  logic               isTopDigit;
  logic               digitNeg;
  logic [PROD_W-1:0]  digitExt;
  logic [PROD_W-1:0]  rawProd;
  logic [PROD_W-1:0]  stepTerm;

  assign sel        = ctl.idx[SEL_W-1:0];
  assign digit      = digitArr[sel];
  assign isTopDigit = halfQ ? (sel == SEL_W'(HALF_TOP)) : (sel == SEL_W'(FULL_TOP));
  // only the most significant digit of a signed multiplier carries weight -2^(k-1)
  assign digitNeg   = signedQ && isTopDigit && digit[DIGIT_W-1];
  assign digitExt   = {{(PROD_W-DIGIT_W){digitNeg}}, digit};
  assign rawProd    = aQ * digitExt;
  assign stepTerm   = shiftedArr[sel];

  for (genvar g = 0; g < FULL_STEPS; g++) begin : gDigit
    assign digitArr[g]   = bQ[g*DIGIT_W +: DIGIT_W];
    assign shiftedArr[g] = rawProd << (g * DIGIT_W);
  end

  // flag formation from the completed accumulator
  logic [FLAG_W-1:0] nextFlags;
  logic [FLAG_W-1:0] nextWe;
  logic [DATA_W-1:0] accHi;
  logic [DATA_W-1:0] accLo;

  assign accHi = accQ[PROD_W-1:DATA_W];
  assign accLo = accQ[DATA_W-1:0];

  always_comb begin
    nextFlags = '0;
    nextWe    = '0;
    nextWe[FLAG_N] = 1'b1;
    nextWe[FLAG_Z] = 1'b1;
    if (halfQ) begin
      nextFlags[FLAG_N] = accLo[DATA_W-1];
      nextFlags[FLAG_Z] = (accLo == '0);
    end else begin
      nextWe[FLAG_V]    = 1'b1;
      nextFlags[FLAG_N] = accQ[PROD_W-1];
      nextFlags[FLAG_Z] = (accQ == '0);
      nextFlags[FLAG_V] = signedQ ? (accHi != {DATA_W{accLo[DATA_W-1]}})
                                  : (accHi != '0);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      aQ      <= '0;
      bQ      <= '0;
      halfQ   <= 1'b0;
      signedQ <= 1'b0;
      accQ    <= '0;
      mdHiQ   <= '0;
      mdLoQ   <= '0;
      flagsQ  <= '0;
      flagWeQ <= '0;
    end else begin
      flagWeQ <= '0;
      if (ctl.load) begin
        aQ      <= aExt;
        bQ      <= bLoad;
        halfQ   <= inHalf;
        signedQ <= inSigned;
        accQ    <= '0;
      end
      if (ctl.step) begin
        accQ <= accQ + stepTerm;
      end
      if (ctl.write) begin
        mdLoQ   <= accLo;
        if (!halfQ) mdHiQ <= accHi;
        flagsQ  <= nextFlags;
        flagWeQ <= nextWe;
      end
    end
  end

  assign mdHi   = mdHiQ;
  assign mdLo   = mdLoQ;
  assign flags  = flagsQ;
  assign flagWe = flagWeQ;

endmodule

// File: rtl/mul_unit.sv
module mul_unit
  import mul_unit_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int DIGIT_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [1:0]        op,
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  output logic              busy,
  output logic              done,
  output logic [DATA_W-1:0] mdHi,
  output logic [DATA_W-1:0] mdLo,
  output logic [3:0]        flags,
  output logic [3:0]        flagWe
);

  mulCtl_t ctl;

  mul_unit_ctrl #(.DATA_W(DATA_W), .DIGIT_W(DIGIT_W)) uCtrl (
    .clk   (clk),
    .rstN  (rstN),
    .start (start),
    .op    (op),
    .ctl   (ctl),
    .busy  (busy),
    .done  (done)
  );

  mul_unit_dp #(.DATA_W(DATA_W), .DIGIT_W(DIGIT_W)) uDp (
    .clk    (clk),
    .rstN   (rstN),
    .ctl    (ctl),
    .op     (op),
    .opA    (opA),
    .opB    (opB),
    .mdHi   (mdHi),
    .mdLo   (mdLo),
    .flags  (flags),
    .flagWe (flagWe)
  );

endmodule

// File: rtl/mul_unit_chk.sv
module mul_unit_chk #(
  parameter int DATA_W  = 32,
  parameter int DIGIT_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              start,
  input logic [1:0]        op,
  input logic [DATA_W-1:0] opA,
  input logic [DATA_W-1:0] opB,
  input logic              busy,
  input logic              done,
  input logic [DATA_W-1:0] mdHi,
  input logic [DATA_W-1:0] mdLo,
  input logic [3:0]        flags,
  input logic [3:0]        flagWe
);

  localparam int FULL_LAT = DATA_W / DIGIT_W + 1;
  localparam int HALF_LAT = (DATA_W / 2) / DIGIT_W + 1;

  logic [7:0] edgeCnt;
  logic [7:0] expLat;
  logic       halfLat;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      edgeCnt <= '0;
      expLat  <= '0;
      halfLat <= 1'b0;
    end else if (start && !busy) begin
      edgeCnt <= '0;
      expLat  <= op[1] ? 8'(HALF_LAT) : 8'(FULL_LAT);
      halfLat <= op[1];
    end else if (busy) begin
      edgeCnt <= edgeCnt + 1'b1;
    end
  end

  // R4 / R6: done arrives exactly the op latency after acceptance
  a_r4_latency: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (edgeCnt == expLat));

  a_r4_busy_clear: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy);

  a_r5_done_pulse: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  a_r5_results_hold: assert property (@(posedge clk) disable iff (!rstN)
    !done |-> ($stable(mdLo) && $stable(mdHi) && $stable(flags)));

  a_r3_hi_kept: assert property (@(posedge clk) disable iff (!rstN)
    (done && halfLat) |-> $stable(mdHi));

  a_r7_we_full: assert property (@(posedge clk) disable iff (!rstN)
    (done && !halfLat) |-> (flagWe == 4'b1110));

  a_r7_zero_full: assert property (@(posedge clk) disable iff (!rstN)
    (done && !halfLat) |-> (flags[2] == ({mdHi, mdLo} == '0)));

  a_r8_we_half: assert property (@(posedge clk) disable iff (!rstN)
    (done && halfLat) |-> (flagWe == 4'b1100));

  a_r8_neg_half: assert property (@(posedge clk) disable iff (!rstN)
    (done && halfLat) |-> (flags[3] == mdLo[DATA_W-1]));

  a_r9_we_idle: assert property (@(posedge clk) disable iff (!rstN)
    !done |-> (flagWe == 4'b0000));

endmodule

bind mul_unit mul_unit_chk #(.DATA_W(DATA_W), .DIGIT_W(DIGIT_W)) uChk (.*);

// File: tb/mul_unit_test.sv
module mul_unit_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [1:0]  op = 2'b00;
  logic [31:0] opA = '0;
  logic [31:0] opB = '0;
  logic        busy, done;
  logic [31:0] mdHi, mdLo;
  logic [3:0]  flags, flagWe;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;
  logic [31:0] hiModel = '0;
  logic [31:0] loModel = '0;

  always #2 clk = ~clk;  // 250 MHz

  mul_unit uut (
    .clk(clk), .rstN(rstN), .start(start), .op(op), .opA(opA), .opB(opB),
    .busy(busy), .done(done), .mdHi(mdHi), .mdLo(mdLo),
    .flags(flags), .flagWe(flagWe)
  );

  task automatic check(input bit ok, input string req,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] calc(input logic [1:0] o,
                                       input logic [31:0] a, input logic [31:0] b);
    logic [63:0] ea, eb;
    if (o[1]) begin
      ea = o[0] ? {48'b0, a[15:0]} : {{48{a[15]}}, a[15:0]};
      eb = o[0] ? {48'b0, b[15:0]} : {{48{b[15]}}, b[15:0]};
    end else begin
      ea = o[0] ? {32'b0, a} : {{32{a[31]}}, a};
      eb = o[0] ? {32'b0, b} : {{32{b[31]}}, b};
    end
    return ea * eb;
  endfunction

  function automatic logic [3:0] expFlags(input logic [1:0] o, input logic [63:0] p);
    logic [3:0] f;
    f = '0;
    if (o[1]) begin
      f[3] = p[31];
      f[2] = (p[31:0] == 32'b0);
    end else begin
      f[3] = p[63];
      f[2] = (p == 64'b0);
      f[1] = o[0] ? (p[63:32] != 32'b0) : (p[63:32] != {32{p[31]}});
    end
    return f;
  endfunction

  // caller is at a negedge with busy low
  task automatic runOp(input logic [1:0] o, input logic [31:0] a, input logic [31:0] b,
                       input bit inject, input bit chained, input bit idle);
    logic [63:0] p;
    int expLat;
    int lat;
    string rp;
    p = calc(o, a, b);
    expLat = o[1] ? 3 : 5;
    rp = o[1] ? "R3" : (o[0] ? "R2" : "R1");
    start = 1'b1; op = o; opA = a; opB = b;
    @(posedge clk); @(negedge clk);
    start = 1'b0; opA = ~a; opB = b ^ 32'h5a5a_a5a5; op = ~o;
    check(busy == 1'b1, chained ? "R11 busy after chained start" : "R4 busy after start",
          64'(busy), 64'd1);
    lat = 0;
    while (!done && lat < 20) begin
      if (inject && lat == 1) begin
        start = 1'b1; op = ~o; opA = $urandom; opB = $urandom;
      end
      if (inject && lat == 2) start = 1'b0;
      @(posedge clk); @(negedge clk);
      lat++;
    end
    start = 1'b0;
    check(lat == expLat, inject ? "R6 latency with start while busy" : "R4 latency",
          64'(lat), 64'(expLat));
    check(busy == 1'b0, "R4 busy low at done", 64'(busy), 64'd0);
    check(mdLo == p[31:0], {rp, " low result"}, 64'(mdLo), 64'(p[31:0]));
    if (o[1]) begin
      check(mdHi == hiModel, "R3 high result kept", 64'(mdHi), 64'(hiModel));
      check(flags[3:2] == expFlags(o, p)[3:2], "R8 half flags N Z",
            64'(flags), 64'(expFlags(o, p)));
      check(flagWe == 4'b1100, "R8 half flag enables", 64'(flagWe), 64'hc);
    end else begin
      check(mdHi == p[63:32], {rp, " high result"}, 64'(mdHi), 64'(p[63:32]));
      hiModel = p[63:32];
      check(flags[3:1] == expFlags(o, p)[3:1], "R7 full flags N Z V",
            64'(flags), 64'(expFlags(o, p)));
      check(flagWe == 4'b1110, "R7 full flag enables", 64'(flagWe), 64'he);
    end
    loModel = p[31:0];
    if (idle) begin
      @(posedge clk); @(negedge clk);
      check(done == 1'b0, "R5 done single pulse", 64'(done), 64'd0);
      check(mdLo == loModel && mdHi == hiModel, "R5 results held after done",
            {mdHi, mdLo}, {hiModel, loModel});
      check(flagWe == 4'b0000, "R9 enables idle", 64'(flagWe), 64'd0);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    bit prevIdle;
    void'($urandom(32'h00c0ffee));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R10 reset state
    check(busy == 0 && done == 0, "R10 control reset", {62'b0, busy, done}, 64'd0);
    check(mdHi == 0 && mdLo == 0, "R10 results reset", {mdHi, mdLo}, 64'd0);
    check(flags == 0 && flagWe == 0, "R10 flags reset", {56'b0, flags, flagWe}, 64'd0);

    // directed corners
    runOp(2'b00, 32'h0000_0000, 32'h1234_5678, 0, 0, 1);  // zero product, Z
    runOp(2'b00, 32'hffff_ffff, 32'hffff_ffff, 0, 0, 1);  // -1 * -1
    runOp(2'b00, 32'h8000_0000, 32'h8000_0000, 0, 0, 1);  // V set
    runOp(2'b00, 32'h8000_0000, 32'h0000_0001, 0, 0, 1);  // fits, N set, V clear
    runOp(2'b01, 32'hffff_ffff, 32'hffff_ffff, 0, 0, 1);
    runOp(2'b01, 32'h0001_0000, 32'h0000_ffff, 0, 0, 1);  // fits unsigned, V clear
    runOp(2'b10, 32'hdead_8000, 32'hbeef_7fff, 0, 0, 1);  // upper bits ignored
    runOp(2'b11, 32'h1234_ffff, 32'h9876_ffff, 0, 0, 1);
    runOp(2'b10, 32'hffff_0000, 32'h0000_0003, 0, 0, 1);  // half zero
    runOp(2'b00, 32'h7fff_ffff, 32'h0000_0002, 1, 0, 0);  // R6 inject
    runOp(2'b11, 32'h0000_00ff, 32'h0000_0101, 0, 1, 0);  // R11 chained
    runOp(2'b10, 32'h0000_8001, 32'h0000_8001, 1, 1, 1);

    prevIdle = 1'b1;
    for (int i = 0; i < 400; i++) begin
      logic [1:0]  o;
      logic [31:0] a, b;
      bit inj, idl;
      o = 2'($urandom % 4);
      a = $urandom;
      b = $urandom;
      if ($urandom % 8 == 0) a = ($urandom % 2) ? 32'h8000_0000 : 32'hffff_ffff;
      if ($urandom % 8 == 0) b = ($urandom % 2) ? 32'h0 : 32'h7fff_ffff;
      inj = ($urandom % 5 == 0);
      idl = ($urandom % 2 == 0);
      runOp(o, a, b, inj, !prevIdle, idl);
      prevIdle = idl;
    end

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule